// File: doc/BRIEF.md
# Receive Byte Packer with Left-Over Reporting

This block sits between the byte-wide receive side of a SCSI data path and the write port of a host bus master. It takes bytes in arrival order and packs them big-endian into 32-bit words. Each completed word goes out on a valid/ready port with a per-byte enable. When the buffer start address is only halfword aligned (address bit 1 set), a halfword mode packs two bytes at a time and writes them on the lower two byte lanes. Address generation and the host bus protocol are handled elsewhere.

If the transfer stops before a word is complete, the block does not write the partial word. The trailing bytes stay in two 16-bit pack registers that can be read, and a 2-bit left-over field gives how many bytes remain. Software then copies those bytes by hand. A synchronous FIFO reset clears everything. In send direction the packer takes no bytes and the left-over field reads zero.

The control is a two-state machine. In `ST_FILL` it accepts bytes and steers each into a byte lane. On the byte that completes a word or halfword it takes the transition FILL→POST. In `ST_POST` it holds the word on the output, and the transition POST→FILL happens on the output handshake. A FIFO reset forces the transition any→FILL from either state.

Top module: `rx_byte_packer`

## Requirements
- R1: After reset, `out_valid` is 0, `lob` is 0, and `pack_hi` and `pack_lo` are 0. With `dir_send`=0, `halt`=0 and `fifo_clr`=0, `in_ready` is 1.
- R2: In normal mode, bytes fill the lanes in this order: `pack_hi[15:8]`, `pack_hi[7:0]`, `pack_lo[15:8]`, `pack_lo[7:0]`. Lanes not yet filled since the last write or clear read 0.
- R3: In normal mode, the fourth byte of a group raises `out_valid` on the next cycle. The word has `out_be`=4'b1111 and `out_data` = {byte0, byte1, byte2, byte3}, with byte0 in bits 31:24.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_be` hold, and `in_ready` is 0.
- R5: `lob` gives the number of bytes received but not yet posted: 1, 2 or 3, and 0 when none remain. After a word is posted, `lob` is 0 and the pack registers read 0.
- R6: With `hw_mode`=1, the first byte of a pair goes to `pack_lo[15:8]` and the second to `pack_lo[7:0]`. Each pair is written with `out_be`=4'b0011 and `out_data` = {16'h0, byte0, byte1}. `pack_hi` stays 0.
- R7: With `hw_mode`=1, at most one byte is left over. It reads as `lob`=1 and sits in `pack_lo[15:8]`.
- R8: `fifo_clr`=1 drops any pending word and clears the pack registers and `lob` on the next cycle. In the same cycle it holds `in_ready` at 0, so a byte offered then is not taken.
- R9: With `dir_send`=1, `lob` reads 0 and `in_ready` is 0. The bytes held stay untouched and report again once `dir_send` returns to 0.
- R10: With `halt`=1, `in_ready` is 0 and the pack registers and `lob` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_clr | input | 1 | Synchronous FIFO reset: drops the pending word and clears the pack state |
| dir_send | input | 1 | 1 = send direction (packer idle), 0 = receive |
| hw_mode | input | 1 | Halfword pack mode (start address bit 1 set) |
| halt | input | 1 | Stops accepting bytes; held state is kept |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | 8 | Incoming byte |
| out_valid | output | 1 | Word write request |
| out_ready | input | 1 | Word write accepted |
| out_data | output | 32 | Packed word, big-endian |
| out_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| pack_hi | output | 16 | Upper pack register (first two trailing bytes) |
| pack_lo | output | 16 | Lower pack register (third trailing byte, or halfword-mode byte) |
| lob | output | 2 | Count of left-over bytes not written |

## Verification
The assertions assume that `hw_mode` changes only while nothing is held: `lob` is 0 and no word is pending, normally right after a FIFO reset. They also assume that `out_ready` is not used to retract a word. Under these conditions the halfword left-over bound and the full-word checks are meaningful. The stimulus follows this rule: every sweep run starts with a `fifo_clr` pulse and sets the mode only in the cycle after it. Inputs are driven shortly after the rising edge and outputs are read on the falling edge, so that the pack registers and `lob` are compared only after the final byte has settled.

// File: rtl/rx_pack_pkg.sv
package rx_pack_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_POST = 1'b1
    } pack_state_e;

endpackage

// File: rtl/rx_pack_ctrl.sv
module rx_pack_ctrl
    import rx_pack_pkg::*;
#(
    parameter int LANES = 4,
    localparam int CNT_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_clr,
    input  logic             dir_send,
    input  logic             hw_mode,
    input  logic             halt,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             take,
    output logic [CNT_W-1:0] lane_sel,
    output logic             out_valid,
    output logic             post_fire,
    output logic [CNT_W-1:0] fill_cnt
);

    localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(LANES - 1);
    localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(1);
    localparam logic [CNT_W-1:0] HALF_BASE = CNT_W'(LANES / 2);

    pack_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last_byte;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs and next state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        state_d   = state_q;
        cnt_d     = cnt_q;
        last_byte = hw_mode ? (cnt_q == LAST_HALF) : (cnt_q == LAST_FULL);
        lane_sel  = hw_mode ? (HALF_BASE + cnt_q) : cnt_q;
        unique case (state_q)
            ST_FILL: begin
                in_ready = !dir_send && !halt && !fifo_clr;
                if (in_valid && in_ready) begin
                    if (last_byte) begin
                        cnt_d   = '0;
                        state_d = ST_POST;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_POST: begin
                out_valid = 1'b1;
                if (out_ready) state_d = ST_FILL;
            end
            default: state_d = ST_FILL;
        endcase
        if (fifo_clr) begin
            state_d = ST_FILL;
            cnt_d   = '0;
        end
        take      = in_valid && in_ready;
        post_fire = out_valid && out_ready && !fifo_clr;
        fill_cnt  = cnt_q;
    end

endmodule

// File: rtl/rx_pack_lanes.sv
module rx_pack_lanes #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int CNT_W  = $clog2(LANES),
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [CNT_W-1:0]  lane_sel,
    input  logic [BYTE_W-1:0] din,
    output logic [WORD_W-1:0] lanes_flat
);

    // lane 0 holds the first byte and maps to the most significant bits
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (clear) begin
                lane_q <= '0;
            end else if (take && (lane_sel == CNT_W'(g))) begin
                lane_q <= din;
            end
        end
        assign lanes_flat[WORD_W-1-g*BYTE_W -: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/rx_pack_fmt.sv
module rx_pack_fmt #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int CNT_W  = $clog2(LANES),
    localparam int WORD_W = BYTE_W * LANES,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic              hw_mode,
    input  logic              dir_send,
    input  logic [CNT_W-1:0]  fill_cnt,
    input  logic [WORD_W-1:0] lanes_flat,
    output logic [WORD_W-1:0] out_data,
    output logic [LANES-1:0]  out_be,
    output logic [HALF_W-1:0] pack_hi,
    output logic [HALF_W-1:0] pack_lo,
    output logic [CNT_W-1:0]  lob
);

    localparam logic [LANES-1:0] BE_FULL = '1;
    localparam logic [LANES-1:0] BE_HALF = {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}};

    always_comb begin
        pack_hi  = lanes_flat[WORD_W-1:HALF_W];
        pack_lo  = lanes_flat[HALF_W-1:0];
        out_data = hw_mode ? {{HALF_W{1'b0}}, lanes_flat[HALF_W-1:0]} : lanes_flat;
        out_be   = hw_mode ? BE_HALF : BE_FULL;
        lob      = dir_send ? '0 : fill_cnt;
    end

endmodule

// File: rtl/rx_byte_packer.sv
module rx_byte_packer #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int CNT_W  = $clog2(LANES),
    localparam int WORD_W = BYTE_W * LANES,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_clr,
    input  logic              dir_send,
    input  logic              hw_mode,
    input  logic              halt,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [LANES-1:0]  out_be,
    output logic [HALF_W-1:0] pack_hi,
    output logic [HALF_W-1:0] pack_lo,
    output logic [CNT_W-1:0]  lob
);

    logic             take;
    logic             post_fire;
    logic [CNT_W-1:0] lane_sel;
    logic [CNT_W-1:0] fill_cnt;
    logic [WORD_W-1:0] lanes_flat;

    rx_pack_ctrl #(.LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_clr  (fifo_clr),
        .dir_send  (dir_send),
        .hw_mode   (hw_mode),
        .halt      (halt),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .take      (take),
        .lane_sel  (lane_sel),
        .out_valid (out_valid),
        .post_fire (post_fire),
        .fill_cnt  (fill_cnt)
    );

    rx_pack_lanes #(.BYTE_W(BYTE_W), .LANES(LANES)) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (fifo_clr || post_fire),
        .take       (take),
        .lane_sel   (lane_sel),
        .din        (in_data),
        .lanes_flat (lanes_flat)
    );

    rx_pack_fmt #(.BYTE_W(BYTE_W), .LANES(LANES)) u_fmt (
        .hw_mode    (hw_mode),
        .dir_send   (dir_send),
        .fill_cnt   (fill_cnt),
        .lanes_flat (lanes_flat),
        .out_data   (out_data),
        .out_be     (out_be),
        .pack_hi    (pack_hi),
        .pack_lo    (pack_lo),
        .lob        (lob)
    );

endmodule

// File: rtl/rx_byte_packer_chk.sv
module rx_byte_packer_chk #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int CNT_W  = $clog2(LANES),
    localparam int WORD_W = BYTE_W * LANES,
    localparam int HALF_W = WORD_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_clr,
    input logic              dir_send,
    input logic              hw_mode,
    input logic              halt,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic [LANES-1:0]  out_be,
    input logic [HALF_W-1:0] pack_hi,
    input logic [HALF_W-1:0] pack_lo,
    input logic [CNT_W-1:0]  lob
);

    assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !fifo_clr |=> out_valid && $stable(out_data) && $stable(out_be));

    assert_no_take_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_full_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_mode && !fifo_clr && in_valid && in_ready && lob == CNT_W'(LANES - 1)
        |=> out_valid && out_be == {LANES{1'b1}} && lob == '0);

    assert_half_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mode && out_valid |-> out_data[WORD_W-1:HALF_W] == '0 && pack_hi == '0);

    assert_half_lob_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mode && !fifo_clr && !$rose(hw_mode) |-> lob <= CNT_W'(1));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> !out_valid && lob == '0 && pack_hi == '0 && pack_lo == '0);

    assert_send_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dir_send |-> !in_ready && lob == '0);

    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !fifo_clr && !out_valid |=> $stable(pack_hi) && $stable(pack_lo));

endmodule

bind rx_byte_packer rx_byte_packer_chk #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_clr  (fifo_clr),
    .dir_send  (dir_send),
    .hw_mode   (hw_mode),
    .halt      (halt),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_be    (out_be),
    .pack_hi   (pack_hi),
    .pack_lo   (pack_lo),
    .lob       (lob)
);

// File: tb/rx_byte_packer_test.sv
module rx_byte_packer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_clr = 1'b0;
    logic        dir_send = 1'b0;
    logic        hw_mode = 1'b0;
    logic        halt = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [3:0]  out_be;
    logic [15:0] pack_hi;
    logic [15:0] pack_lo;
    logic [1:0]  lob;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] wq_data[$];
    logic [3:0]  wq_be[$];

    always #2 clk = ~clk;

    rx_byte_packer uut (
        .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .dir_send(dir_send),
        .hw_mode(hw_mode), .halt(halt), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_be(out_be), .pack_hi(pack_hi),
        .pack_lo(pack_lo), .lob(lob)
    );

    // record words that are handed over at the coming rising edge
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && !fifo_clr) begin
            wq_data.push_back(out_data);
            wq_be.push_back(out_be);
        end
    end

    function automatic logic [7:0] bv(int i, int s);
        return 8'(i * 37 + s * 59 + 3);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clr_pulse;
        fifo_clr = 1'b1;
        step(1);
        fifo_clr = 1'b0;
    endtask

    task automatic push_byte(logic [7:0] b);
        logic got;
        got = 1'b0;
        in_valid = 1'b1;
        in_data = b;
        while (!got) begin
            @(negedge clk);
            got = in_ready;
            step(1);
        end
        in_valid = 1'b0;
    endtask

    task automatic run_normal(int n, int s);
        int q, r;
        clr_pulse();
        wq_data.delete();
        wq_be.delete();
        for (int i = 0; i < n; i++) push_byte(bv(i, s));
        step(3);
        @(negedge clk);
        q = n / 4;
        r = n % 4;
        check("R3 word count", 32'(wq_data.size()), 32'(q));
        for (int w = 0; w < q && w < wq_data.size(); w++) begin
            check("R3 word data", wq_data[w],
                  {bv(4*w, s), bv(4*w+1, s), bv(4*w+2, s), bv(4*w+3, s)});
            check("R3 word be", 32'(wq_be[w]), 32'h0000000F);
        end
        check("R5 lob normal", 32'(lob), 32'(r));
        check("R2 pack_hi", 32'(pack_hi),
              {16'h0, (r >= 1) ? bv(4*q, s) : 8'h00, (r >= 2) ? bv(4*q+1, s) : 8'h00});
        check("R2 pack_lo", 32'(pack_lo),
              {16'h0, (r >= 3) ? bv(4*q+2, s) : 8'h00, 8'h00});
        check("R5 no pending", 32'(out_valid), 32'h0);
        step(1);
    endtask

    task automatic run_half(int n, int s);
        int q, r;
        clr_pulse();
        hw_mode = 1'b1;
        wq_data.delete();
        wq_be.delete();
        for (int i = 0; i < n; i++) push_byte(bv(i, s));
        step(3);
        @(negedge clk);
        q = n / 2;
        r = n % 2;
        check("R6 half count", 32'(wq_data.size()), 32'(q));
        for (int w = 0; w < q && w < wq_data.size(); w++) begin
            check("R6 half data", wq_data[w], {16'h0, bv(2*w, s), bv(2*w+1, s)});
            check("R6 half be", 32'(wq_be[w]), 32'h00000003);
        end
        check("R7 lob half", 32'(lob), 32'(r));
        check("R7 pack_lo", 32'(pack_lo), {16'h0, (r == 1) ? bv(2*q, s) : 8'h00, 8'h00});
        check("R6 pack_hi zero", 32'(pack_hi), 32'h0);
        step(1);
        clr_pulse();
        hw_mode = 1'b0;
        step(1);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        @(negedge clk);
        // R1 reset state
        check("R1 out_valid", 32'(out_valid), 32'h0);
        check("R1 lob", 32'(lob), 32'h0);
        check("R1 pack_hi", 32'(pack_hi), 32'h0);
        check("R1 pack_lo", 32'(pack_lo), 32'h0);
        check("R1 in_ready", 32'(in_ready), 32'h1);
        step(1);

        // R2 R3 R5 sweep over lengths and data seeds
        for (int s = 0; s < 3; s++)
            for (int n = 0; n < 10; n++) run_normal(n, s);

        // R6 R7 halfword sweep
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 6; n++) run_half(n, s);

        // R4 stall: word held, no intake
        clr_pulse();
        wq_data.delete();
        wq_be.delete();
        out_ready = 1'b0;
        for (int i = 0; i < 4; i++) push_byte(bv(i, 7));
        in_valid = 1'b1;
        in_data = 8'hEE;
        step(3);
        @(negedge clk);
        check("R4 held valid", 32'(out_valid), 32'h1);
        check("R4 no intake", 32'(in_ready), 32'h0);
        check("R4 held data", out_data, {bv(0, 7), bv(1, 7), bv(2, 7), bv(3, 7)});
        check("R5 lob while posted", 32'(lob), 32'h0);
        step(1);
        in_valid = 1'b0;
        out_ready = 1'b1;
        step(3);
        @(negedge clk);
        check("R4 one word", 32'(wq_data.size()), 32'h1);
        check("R4 released", 32'(out_valid), 32'h0);
        check("R5 cleared after post", 32'(pack_hi), 32'h0);
        step(1);

        // R10 halt holds state
        clr_pulse();
        push_byte(8'hA1);
        push_byte(8'hB2);
        halt = 1'b1;
        in_valid = 1'b1;
        in_data = 8'h5C;
        @(negedge clk);
        check("R10 in_ready", 32'(in_ready), 32'h0);
        step(3);
        @(negedge clk);
        check("R10 lob hold", 32'(lob), 32'h2);
        check("R10 pack_hi hold", 32'(pack_hi), 32'h0000A1B2);
        check("R10 pack_lo hold", 32'(pack_lo), 32'h0);
        step(1);
        in_valid = 1'b0;
        halt = 1'b0;

        // R9 send direction
        clr_pulse();
        push_byte(8'hC3);
        dir_send = 1'b1;
        in_valid = 1'b1;
        in_data = 8'h77;
        @(negedge clk);
        check("R9 lob zero", 32'(lob), 32'h0);
        check("R9 in_ready", 32'(in_ready), 32'h0);
        step(3);
        in_valid = 1'b0;
        dir_send = 1'b0;
        step(1);
        @(negedge clk);
        check("R9 lob back", 32'(lob), 32'h1);
        check("R9 pack_hi kept", 32'(pack_hi), 32'h0000C300);
        step(1);

        // R8 clear drops pending word and blocks a byte offered with it
        clr_pulse();
        wq_data.delete();
        wq_be.delete();
        out_ready = 1'b0;
        for (int i = 0; i < 4; i++) push_byte(bv(i, 9));
        step(1);
        fifo_clr = 1'b1;
        @(negedge clk);
        check("R8 ready low in clear", 32'(in_ready), 32'h0);
        step(1);
        fifo_clr = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        check("R8 word dropped", 32'(out_valid), 32'h0);
        check("R8 lob", 32'(lob), 32'h0);
        check("R8 pack_hi", 32'(pack_hi), 32'h0);
        check("R8 pack_lo", 32'(pack_lo), 32'h0);
        step(1);
        push_byte(8'h4D);
        fifo_clr = 1'b1;
        in_valid = 1'b1;
        in_data = 8'h99;
        step(1);
        fifo_clr = 1'b0;
        in_valid = 1'b0;
        step(1);
        @(negedge clk);
        check("R8 byte with clear ignored", 32'(lob), 32'h0);
        check("R8 pack after clear", 32'(pack_hi), 32'h0);
        check("R8 nothing written", 32'(wq_data.size()), 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule